// File: doc/BRIEF.md
# Fixed-Pattern Serial Sequence Generator

This block emits the serial bit pattern 1, 0, 0, 1 over and over, one bit per enabled clock, starting with the leading 1. It is a 4-bit register that shifts toward its most significant bit on every enabled edge. The new least significant bit comes from combinational next-bit logic that looks only at the present register contents. The serial output is taken from the most significant flop. The whole register is also brought out, so that surrounding logic or a bench can watch the state walk through its cycle.

The feedback function is worked out when the block is elaborated, from a pattern constant. It has two jobs. Inside the four-state cycle it reproduces the pattern. For each of the twelve states outside the cycle, the all-zero state among them, it picks the bit that steers the register back into the cycle. This makes the generator self-correcting: an upset flop or a badly chosen start value costs at most two enabled clocks of wrong output.

A synchronous, active-high reset loads the start state. While the shift enable is low, the register holds its state.

Top module: `patgen_1001`

## Requirements
- R1: With `rst` high at a rising clock edge, the register loads the start state 4'b1001 (parameter `SEED_STATE`), whatever `shift_en` is. As a result, `state` reads 1001 and `pat_bit` reads 1 after that edge.
- R2: After reset, with `shift_en` held high, `pat_bit` (equal to `state[3]`) produces 1,0,0,1 and repeats this period-4 pattern without end. The first bit shown after reset is 1.
- R3: On each enabled edge the register shifts one place toward bit 3 and takes the feedback bit into bit 0. The valid cycle is 1001 → 0011 → 0110 → 1100 → 1001, and all four of these states are distinct.
- R4: The all-zero state is never part of the cycle. From 0000, one enabled edge leads to 0001 and a second leads to 0011.
- R5: The feedback bit equals the inverse of `state[1]` for every one of the 16 states. As a result, each of the twelve states outside the cycle reaches a cycle state within two enabled edges and then stays in the cycle.
- R6: With `shift_en` low and `rst` low, `state` and `pat_bit` keep their values across the edge.
- R7: A reset applied in the middle of the pattern, with `shift_en` low, restarts the pattern from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all flops update on its rising edge |
| rst | input | 1 | Synchronous active-high reset; loads the start state |
| shift_en | input | 1 | Advance the register by one place when high |
| pat_bit | output | 1 | Serial pattern bit (most significant flop) |
| state | output | 4 | Present register contents |

## Verification
The hardest case to reach from the ports is recovery from the twelve states outside the cycle. The feedback never drives the register into them, so a correct generator never leaves its cycle on its own. The bench therefore builds sixteen extra copies of the block alongside `uut`, each with a different start-state parameter covering all 16 values. A single reset places every state, 0000 included, in front of the feedback logic at once. The bench then tracks each copy over two enabled edges and beyond, together with random enable and reset traffic on the main instance.

// File: rtl/patgen_pkg.sv
package patgen_pkg;

   localparam int unsigned REG_W = 4;
   localparam int unsigned N_STATES = 2 ** REG_W;
   localparam logic [REG_W-1:0] PATTERN = 4'b1001;

   typedef logic [REG_W-1:0] pg_state_t;

   function automatic pg_state_t rotl(input pg_state_t v, input int unsigned n);
      pg_state_t r;
      r = v;
      for (int unsigned i = 0; i < n; i++) begin
         r = {r[REG_W-2:0], r[REG_W-1]};
      end
      return r;
   endfunction

   function automatic logic in_cycle(input pg_state_t s, input pg_state_t pat);
      logic hit;
      hit = 1'b0;
      for (int unsigned r = 0; r < REG_W; r++) begin
         if (rotl(pat, r) == s) hit = 1'b1;
      end
      return hit;
   endfunction

   function automatic int unsigned period_of(input pg_state_t pat);
      int unsigned p;
      p = REG_W;
      for (int unsigned r = REG_W - 1; r >= 1; r--) begin
         if (rotl(pat, r) == pat) p = r;
      end
      return p;
   endfunction

   // Next-bit table over all states: a state whose kept bits start a
   // rotation of the pattern continues that rotation; any other state
   // picks the bit that makes the following kept bits start one.
   function automatic logic [N_STATES-1:0] build_fb_table(input pg_state_t pat);
      logic [N_STATES-1:0] tbl;
      pg_state_t s;
      pg_state_t rv;
      logic found;
      tbl = '1;
      for (int unsigned k = 0; k < N_STATES; k++) begin
         s = pg_state_t'(k);
         found = 1'b0;
         for (int unsigned r = 0; r < REG_W; r++) begin
            rv = rotl(pat, r);
            if (!found && rv[REG_W-1:1] == s[REG_W-2:0]) begin
               tbl[k] = rv[0];
               found = 1'b1;
            end
         end
         for (int unsigned r = 0; r < REG_W; r++) begin
            rv = rotl(pat, r);
            if (!found && rv[REG_W-1:2] == s[REG_W-3:0]) begin
               tbl[k] = rv[1];
               found = 1'b1;
            end
         end
      end
      return tbl;
   endfunction

endpackage

// File: rtl/patgen_feedback.sv
module patgen_feedback
   import patgen_pkg::*;
#(
   parameter pg_state_t PAT = PATTERN
) (
   input  pg_state_t state,
   output logic      fb
);

   localparam logic [N_STATES-1:0] FB_TABLE = build_fb_table(PAT);

   assign fb = FB_TABLE[state];

endmodule

// File: rtl/patgen_shreg.sv
module patgen_shreg #(
   parameter int unsigned W = 4,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] q
);

   logic [W-1:0] q_r;
   logic [W-1:0] nxt;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_head
         assign nxt[i] = din;
      end else begin : g_body
         assign nxt[i] = q_r[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q_r <= INIT;
      end else if (en) begin
         q_r <= nxt;
      end
   end

   assign q = q_r;

endmodule

// File: rtl/patgen_1001.sv
module patgen_1001
   import patgen_pkg::*;
#(
   parameter int unsigned WIDTH = REG_W,
   parameter logic [REG_W-1:0] SEED_STATE = PATTERN,
   parameter bit OUT_FROM_FB = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift_en,
   output logic             pat_bit,
   output logic [REG_W-1:0] state
);

   if (WIDTH != REG_W) begin : g_bad_width
      $error("patgen_1001: WIDTH must equal the package register width");
   end
   if (PATTERN == '0) begin : g_bad_zero
      $error("patgen_1001: pattern must not be all zero");
   end
   if (period_of(PATTERN) != REG_W) begin : g_bad_period
      $error("patgen_1001: pattern rotations must all be distinct");
   end

   logic      fb;
   pg_state_t q;

   patgen_feedback #(
      .PAT(PATTERN)
   ) u_fb (
      .state(q),
      .fb   (fb)
   );

   patgen_shreg #(
      .W   (REG_W),
      .INIT(SEED_STATE)
   ) u_reg (
      .clk(clk),
      .rst(rst),
      .en (shift_en),
      .din(fb),
      .q  (q)
   );

   if (OUT_FROM_FB) begin : g_tap_fb
      assign pat_bit = fb;
   end else begin : g_tap_msb
      assign pat_bit = q[REG_W-1];
   end

   assign state = q;

endmodule

// File: rtl/patgen_1001_chk.sv
module patgen_1001_chk
   import patgen_pkg::*;
#(
   parameter logic [REG_W-1:0] SEED_STATE = PATTERN
) (
   input logic             clk,
   input logic             rst,
   input logic             shift_en,
   input logic [REG_W-1:0] state
);

   // R1 / R7: reset loads the start state regardless of enable
   p_reset_seed_r1: assert property (@(posedge clk)
      rst |=> state == SEED_STATE);

   // R3: a cycle state steps to its one-place rotation
   p_cycle_step_r3: assert property (@(posedge clk) disable iff (rst)
      (shift_en && in_cycle(state, PATTERN))
      |=> state == {$past(state[REG_W-2:0]), $past(state[REG_W-1])});

   // R4: all-zero leaves toward 0001
   p_zero_exit_r4: assert property (@(posedge clk) disable iff (rst)
      (shift_en && state == '0) |=> state == 4'b0001);

   // R5: two enabled edges from an unused state land in the cycle
   p_recover_r5: assert property (@(posedge clk) disable iff (rst)
      (shift_en && $past(shift_en) && !$past(rst)
       && !in_cycle($past(state), PATTERN))
      |=> in_cycle(state, PATTERN));

   // R6: no enable, no movement
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(state));

endmodule

bind patgen_1001 patgen_1001_chk #(
   .SEED_STATE(SEED_STATE)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .shift_en(shift_en),
   .state   (state)
);

// File: tb/patgen_1001_test.sv
module patgen_1001_test;

   localparam logic [3:0] PAT = 4'b1001;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   always #10 clk = ~clk;

   logic       pat_bit;
   logic [3:0] state;
   logic [15:0] sp_bit;
   logic [3:0]  sp_state [16];

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [3:0] m;
   logic [3:0] sm [16];
   int         pos;

   patgen_1001 uut (
      .clk(clk), .rst(rst), .shift_en(en), .pat_bit(pat_bit), .state(state)
   );

   for (genvar k = 0; k < 16; k++) begin : g_seed
      patgen_1001 #(.SEED_STATE(4'(k))) u_seed (
         .clk(clk), .rst(rst), .shift_en(en),
         .pat_bit(sp_bit[k]), .state(sp_state[k])
      );
   end

   function automatic logic [3:0] nxt(input logic [3:0] s, input logic e);
      return e ? {s[2:0], ~s[1]} : s;
   endfunction

   function automatic bit valid(input logic [3:0] s);
      return (s == 4'b1001) || (s == 4'b0011) || (s == 4'b0110) || (s == 4'b1100);
   endfunction

   task automatic chk4(input string tag, input logic [3:0] act, input logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic chk1(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic tick(input logic r, input logic e);
      rst = r;
      en  = e;
      @(posedge clk);
      @(negedge clk);
      m   = r ? PAT : nxt(m, e);
      pos = r ? 0 : (e ? pos + 1 : pos);
      for (int k = 0; k < 16; k++) sm[k] = r ? 4'(k) : nxt(sm[k], e);
   endtask

   task automatic check_all(input string tag);
      chk4({tag, " uut state"}, state, m);
      chk1({tag, " uut bit"}, pat_bit, m[3]);
      for (int k = 0; k < 16; k++) chk4({tag, " seed"}, sp_state[k], sm[k]);
   endtask

   initial begin
      void'($urandom(32'd1729));
      m = PAT;
      pos = 0;
      @(negedge clk);

      // R1: reset loads 1001, output 1; every seed loads its own value
      tick(1'b1, 1'b0);
      chk4("R1 reset state", state, 4'b1001);
      chk1("R1 reset bit", pat_bit, 1'b1);
      for (int k = 0; k < 16; k++) chk4("R1 seed load", sp_state[k], 4'(k));

      // R4 / R5: unused states recover within two enabled edges
      tick(1'b0, 1'b1);
      chk4("R4 zero first step", sp_state[0], 4'b0001);
      check_all("R5 step1");
      tick(1'b0, 1'b1);
      chk4("R4 zero second step", sp_state[0], 4'b0011);
      for (int k = 0; k < 16; k++) chk1("R5 in cycle after two", valid(sp_state[k]), 1'b1);
      check_all("R5 step2");
      for (int i = 0; i < 6; i++) begin
         tick(1'b0, 1'b1);
         for (int k = 0; k < 16; k++) chk1("R5 stays in cycle", valid(sp_state[k]), 1'b1);
      end

      // R2 / R3: three full periods from a fresh reset
      tick(1'b1, 1'b0);
      chk1("R2 first bit", pat_bit, 1'b1);
      for (int j = 1; j <= 12; j++) begin
         tick(1'b0, 1'b1);
         chk1("R2 pattern bit", pat_bit, PAT[3 - (j % 4)]);
         chk4("R3 cycle state", state, m);
         chk1("R3 state valid", valid(state), 1'b1);
      end

      // R6: hold with enable low
      tick(1'b0, 1'b1);
      for (int i = 0; i < 4; i++) begin
         tick(1'b0, 1'b0);
         chk4("R6 hold state", state, 4'b0011);
         chk1("R6 hold bit", pat_bit, 1'b0);
      end

      // R7: reset mid-pattern with enable low restarts at first bit
      tick(1'b0, 1'b1);
      tick(1'b1, 1'b0);
      chk4("R7 restart state", state, 4'b1001);
      chk1("R7 restart bit", pat_bit, 1'b1);
      tick(1'b0, 1'b1);
      chk1("R7 second bit", pat_bit, 1'b0);

      // Random enable / occasional reset traffic
      for (int i = 0; i < 300; i++) begin
         tick(($urandom % 40) == 0, $urandom % 2);
         check_all("R3 R6 random");
         chk1("R2 random pattern bit", pat_bit, PAT[3 - (pos % 4)]);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule